// File: doc/BRIEF.md
# System Exception Pending and Status Register

This block holds the pending, active and enable state of a small fixed set of system exceptions and of a parameterised number of external interrupts. Peripherals raise single-cycle set-pending pulses, including a dedicated tick input. Software reaches the state through three 32-bit registers: a control/state word, a handler control/status word and a software trigger. System exceptions take vector numbers below 16. External interrupt n takes vector 16+n.

The block always presents the lowest-numbered vector that is both pending and enabled, together with a request flag. A core-side acknowledge strobe makes that vector active. A complete strobe that carries a vector number retires it. The register interface is a plain single-cycle write strobe with a combinational read port. Every pin on the block is plain control or status, so there is no valid/ready handshake and no back-pressure.

Top module: `sysexc_ctrl`

## Requirements
- R1: A pulse on ext_irq_i[n] pends vector 16+n. Vector numbers are: NMI 2, MemManage 4, BusFault 5, UsageFault 6, SVCall 11, DebugMonitor 12, PendSV 14, tick 15. sys_pend_i[v] pends system vector v for those numbers only.
- R2: A write to the control/state word (offset 0x0) with bit 31 set pends NMI. NMI is always enabled.
- R3: In a control/state write, bit 28 pends PendSV. Bit 27 clears PendSV only when bit 28 is zero in the same write.
- R4: In a control/state write, bit 26 pends the tick exception. Bit 25 clears it only when bit 26 is zero in the same write. A pulse on tick_i also pends it.
- R5: A control/state read returns in bits [8:0] the lowest-numbered active vector, or 0 when none is active. Bit 11 reads 1 when at most one vector is active.
- R6: A control/state read returns in bits [20:12] the selected pending vector. Bit 22 reads 1 when any external interrupt is pending. Bits 26, 28 and 31 read the pending state of tick, PendSV and NMI.
- R7: A handler status read (offset 0x4) shows the active state of MemManage, BusFault, UsageFault, SVCall, DebugMonitor, PendSV and tick in bits 0, 1, 3, 7, 8, 10 and 11.
- R8: In the handler status word, bits 12 to 15 read the pending state of UsageFault, MemManage, BusFault and SVCall. Bits 16 to 18 are read/write enables for MemManage, BusFault and UsageFault. A fault that is disabled stays pending but is never selected.
- R9: A write to the trigger register (offset 0x8) pends vector 16+wdata[8:0] when wdata[8:0] is below NUM_EXT. Any other value is ignored.
- R10: The selected vector is the lowest-numbered vector that is pending and enabled. irq_req_o is high exactly when such a vector exists. When it is low, pend_vec_o is 0.
- R11: ack_i while irq_req_o is high makes the selected vector active and clears its pending bit. ack_i while irq_req_o is low has no effect.
- R12: cmpl_i clears the active bit of vector cmpl_vec_i.
- R13: Writes to any other offset are ignored, and reads from any other offset return 0.
- R14: After reset nothing is pending or active, all fault enables are 0, and the control/state word reads 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ext_irq_i | input | NUM_EXT | Set-pending pulses for external interrupts |
| sys_pend_i | input | 16 | Set-pending pulses for system vectors, indexed by vector number |
| tick_i | input | 1 | Tick timer set-pending pulse |
| ack_i | input | 1 | Acknowledge the selected vector |
| cmpl_i | input | 1 | Complete strobe |
| cmpl_vec_i | input | 9 | Vector number to complete |
| irq_req_o | output | 1 | A pending, enabled vector exists |
| pend_vec_o | output | 9 | Selected pending vector |
| act_vec_o | output | 9 | Lowest-numbered active vector |

## Verification
The bench pends each external interrupt on its own and then sweeps every ordered pair of them. The single-source case proves the vector numbering. The pairs show that the lowest number wins and that two active vectors clear the single-level flag. The trigger register is swept across values both inside and outside the interrupt count, with junk in the upper data bits, to find the range edge. All four combinations of each set/clear bit pair are applied from both a pending and an idle start, which tells set-wins apart from clear-wins and from plain toggling. Fault pulses are issued with their enables off and then on, to separate a fault that is pending but masked from one that is selectable.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
  localparam int VW = 9;

  localparam int V_NMI  = 2;
  localparam int V_MEM  = 4;
  localparam int V_BUS  = 5;
  localparam int V_USE  = 6;
  localparam int V_SVC  = 11;
  localparam int V_DBG  = 12;
  localparam int V_PSV  = 14;
  localparam int V_TICK = 15;
  localparam int V_EXT0 = 16;

  // system vectors that exist
  localparam logic [15:0] SYS_IMPL = 16'hD874;

  // packed order of the system summary vectors handed to the register file
  localparam int S_NMI = 0, S_MEM = 1, S_BUS = 2, S_USE = 3;
  localparam int S_SVC = 4, S_DBG = 5, S_PSV = 6, S_TICK = 7;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_HND  = 4'h4;
  localparam logic [3:0] OFF_TRIG = 4'h8;

  typedef struct packed {
    logic          set_nmi;
    logic          set_psv;
    logic          clr_psv;
    logic          set_tick;
    logic          clr_tick;
    logic          trig_vld;
    logic [VW-1:0] trig_num;
  } wr_cmd_t;
endpackage

// File: rtl/sysexc_prio_enc.sv
module sysexc_prio_enc #(
  parameter int W  = 80,
  parameter int OW = 9
) (
  input  logic [W-1:0]  req,
  output logic [OW-1:0] idx,
  output logic          hit
);
  // descending scan: the last match, the lowest index, wins
  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = OW'(i);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysexc_pend_bank.sv
module sysexc_pend_bank #(
  parameter int NVEC = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] pend_set,
  input  logic [NVEC-1:0] pend_clr,
  input  logic [NVEC-1:0] act_set,
  input  logic [NVEC-1:0] act_clr,
  output logic [NVEC-1:0] pend_q,
  output logic [NVEC-1:0] act_q
);
  for (genvar g = 0; g < NVEC; g++) begin : g_cell
    // a set always overrides a clear arriving in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        act_q[g]  <= 1'b0;
      end else begin
        pend_q[g] <= pend_set[g] | (pend_q[g] & ~pend_clr[g]);
        act_q[g]  <= act_set[g]  | (act_q[g]  & ~act_clr[g]);
      end
    end
  end
endmodule

// File: rtl/sysexc_regfile.sv
module sysexc_regfile
  import sysexc_pkg::*;
#(
  parameter int NUM_EXT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [3:0]    addr,
  input  logic [31:0]   wdata,
  output wr_cmd_t       cmd,
  output logic [2:0]    fault_en,
  input  logic [VW-1:0] act_vec,
  input  logic [VW-1:0] pend_vec,
  input  logic          multi_act,
  input  logic          ext_any,
  input  logic [7:0]    sys_pend,
  input  logic [7:0]    sys_act,
  output logic [31:0]   rdata
);
  logic wr_ctrl, wr_hnd, wr_trig;
  assign wr_ctrl = wen && (addr == OFF_CTRL);
  assign wr_hnd  = wen && (addr == OFF_HND);
  assign wr_trig = wen && (addr == OFF_TRIG);

  always_comb begin
    cmd.set_nmi  = wr_ctrl & wdata[31];
    cmd.set_psv  = wr_ctrl & wdata[28];
    cmd.clr_psv  = wr_ctrl & wdata[27] & ~wdata[28];
    cmd.set_tick = wr_ctrl & wdata[26];
    cmd.clr_tick = wr_ctrl & wdata[25] & ~wdata[26];
    cmd.trig_num = wdata[VW-1:0];
    cmd.trig_vld = wr_trig && (int'(wdata[VW-1:0]) < NUM_EXT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fault_en <= 3'b000;
    else if (wr_hnd) fault_en <= wdata[18:16];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL: begin
        rdata[VW-1:0] = act_vec;
        rdata[11]     = ~multi_act;
        rdata[20:12]  = pend_vec;
        rdata[22]     = ext_any;
        rdata[26]     = sys_pend[S_TICK];
        rdata[28]     = sys_pend[S_PSV];
        rdata[31]     = sys_pend[S_NMI];
      end
      OFF_HND: begin
        rdata[0]     = sys_act[S_MEM];
        rdata[1]     = sys_act[S_BUS];
        rdata[3]     = sys_act[S_USE];
        rdata[7]     = sys_act[S_SVC];
        rdata[8]     = sys_act[S_DBG];
        rdata[10]    = sys_act[S_PSV];
        rdata[11]    = sys_act[S_TICK];
        rdata[12]    = sys_pend[S_USE];
        rdata[13]    = sys_pend[S_MEM];
        rdata[14]    = sys_pend[S_BUS];
        rdata[15]    = sys_pend[S_SVC];
        rdata[18:16] = fault_en;
      end
      default: rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{wdata[30:29], wdata[24:19], wdata[15:9],
                         sys_pend[S_DBG], sys_act[S_NMI]};
endmodule

// File: rtl/sysexc_ctrl.sv
module sysexc_ctrl
  import sysexc_pkg::*;
#(
  parameter int NUM_EXT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wen,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [15:0]        sys_pend_i,
  input  logic               tick_i,
  input  logic               ack_i,
  input  logic               cmpl_i,
  input  logic [VW-1:0]      cmpl_vec_i,
  output logic               irq_req_o,
  output logic [VW-1:0]      pend_vec_o,
  output logic [VW-1:0]      act_vec_o
);
  localparam int NVEC = V_EXT0 + NUM_EXT;
  localparam logic [NVEC-1:0] ONE = NVEC'(1);

  wr_cmd_t         cmd;
  logic [2:0]      fault_en;
  logic [NVEC-1:0] pend_q, act_q;
  logic [NVEC-1:0] pend_set, pend_clr, act_set, act_clr;
  logic [NVEC-1:0] en_m, avail;
  logic            act_hit, multi_act, ext_any;
  logic [7:0]      sys_pend, sys_act;

  always_comb begin
    en_m        = '1;
    en_m[V_MEM] = fault_en[0];
    en_m[V_BUS] = fault_en[1];
    en_m[V_USE] = fault_en[2];
  end
  assign avail = pend_q & en_m;

  sysexc_prio_enc #(.W(NVEC), .OW(VW)) u_pend_enc (
    .req(avail), .idx(pend_vec_o), .hit(irq_req_o)
  );
  sysexc_prio_enc #(.W(NVEC), .OW(VW)) u_act_enc (
    .req(act_q), .idx(act_vec_o), .hit(act_hit)
  );

  assign multi_act = |(act_q & (act_q - ONE));
  assign ext_any   = |pend_q[NVEC-1:V_EXT0];

  always_comb begin
    pend_set              = '0;
    pend_set[15:0]        = sys_pend_i & SYS_IMPL;
    pend_set[NVEC-1:V_EXT0] = ext_irq_i;
    pend_set[V_NMI]       = pend_set[V_NMI]  | cmd.set_nmi;
    pend_set[V_PSV]       = pend_set[V_PSV]  | cmd.set_psv;
    pend_set[V_TICK]      = pend_set[V_TICK] | cmd.set_tick | tick_i;
    if (cmd.trig_vld)
      pend_set = pend_set | (ONE << (int'(cmd.trig_num) + V_EXT0));
  end

  always_comb begin
    act_set = (ack_i && irq_req_o) ? (ONE << pend_vec_o) : '0;
    act_clr = (cmpl_i && (int'(cmpl_vec_i) < NVEC)) ? (ONE << cmpl_vec_i) : '0;
    pend_clr         = act_set;
    pend_clr[V_PSV]  = pend_clr[V_PSV]  | cmd.clr_psv;
    pend_clr[V_TICK] = pend_clr[V_TICK] | cmd.clr_tick;
  end

  sysexc_pend_bank #(.NVEC(NVEC)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .act_set(act_set), .act_clr(act_clr),
    .pend_q(pend_q), .act_q(act_q)
  );

  assign sys_pend = {pend_q[V_TICK], pend_q[V_PSV], pend_q[V_DBG], pend_q[V_SVC],
                     pend_q[V_USE], pend_q[V_BUS], pend_q[V_MEM], pend_q[V_NMI]};
  assign sys_act  = {act_q[V_TICK], act_q[V_PSV], act_q[V_DBG], act_q[V_SVC],
                     act_q[V_USE], act_q[V_BUS], act_q[V_MEM], act_q[V_NMI]};

  sysexc_regfile #(.NUM_EXT(NUM_EXT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .cmd(cmd), .fault_en(fault_en),
    .act_vec(act_vec_o), .pend_vec(pend_vec_o),
    .multi_act(multi_act), .ext_any(ext_any),
    .sys_pend(sys_pend), .sys_act(sys_act),
    .rdata(reg_rdata)
  );

  logic unused_hit;
  assign unused_hit = act_hit;
endmodule

// File: rtl/sysexc_ctrl_chk.sv
module sysexc_ctrl_chk #(
  parameter int NVEC = 80
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wen,
  input logic [3:0]      reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            tick_i,
  input logic [15:0]     sys_pend_i,
  input logic            ack_i,
  input logic            cmpl_i,
  input logic [8:0]      cmpl_vec_i,
  input logic            irq_req_o,
  input logic [8:0]      pend_vec_o,
  input logic [NVEC-1:0] pend_q,
  input logic [NVEC-1:0] act_q
);
  logic [511:0] pend_x, act_x;
  assign pend_x = 512'(pend_q);
  assign act_x  = 512'(act_q);

  logic ctrl_wr;
  assign ctrl_wr = reg_wen && (reg_addr == 4'h0);

  p_nmi_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[31]) |=> pend_x[2]);

  p_psv_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[28] && reg_wdata[27]) |=> pend_x[14]);

  p_tick_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[25] && !reg_wdata[26] && !tick_i && !sys_pend_i[15])
      |=> !pend_x[15]);

  p_sel_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> pend_x[pend_vec_o]);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_o |-> (pend_vec_o == 9'd0));

  p_ack_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_req_o) |=> act_x[$past(pend_vec_o)]);

  p_cmpl_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && !(ack_i && irq_req_o && (pend_vec_o == cmpl_vec_i)))
      |=> !act_x[$past(cmpl_vec_i)]);
endmodule

bind sysexc_ctrl sysexc_ctrl_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tick_i(tick_i), .sys_pend_i(sys_pend_i),
  .ack_i(ack_i), .cmpl_i(cmpl_i), .cmpl_vec_i(cmpl_vec_i),
  .irq_req_o(irq_req_o), .pend_vec_o(pend_vec_o),
  .pend_q(pend_q), .act_q(act_q)
);

// File: tb/sysexc_ctrl_tb_top.sv
module sysexc_ctrl_tb_top;
  localparam int NE = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wen = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NE-1:0] ext_irq_i = '0;
  logic [15:0]   sys_pend_i = '0;
  logic          tick_i = 1'b0;
  logic          ack_i = 1'b0;
  logic          cmpl_i = 1'b0;
  logic [8:0]    cmpl_vec_i = '0;
  logic          irq_req_o;
  logic [8:0]    pend_vec_o, act_vec_o;

  always #10 clk = ~clk;

  sysexc_ctrl #(.NUM_EXT(NE)) dut_i (.*);

  int checks = 0, errors = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
  endtask

  task automatic cmpl(int v);
    cmpl_i = 1'b1; cmpl_vec_i = 9'(v); cyc(); cmpl_i = 1'b0;
  endtask

  task automatic drain();
    int v;
    #1;
    while (irq_req_o) begin
      v = int'(pend_vec_o); ack(); cmpl(v); #1;
    end
  endtask

  function automatic logic [31:0] pendf(int v);
    return 32'(v) << 12;
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        pv;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // R14 reset state
    rd(4'h0, d); chk("R14 ctrl reset", d, 32'h800);
    rd(4'h4, d); chk("R14 hnd reset", d, 32'h0);
    chk("R14 no request", {31'd0, irq_req_o}, 32'd0);

    // R1 R6 R10 R11 R5 R12 single source sweep
    for (int n = 0; n < NE; n++) begin
      ext_irq_i[n] = 1'b1; cyc(); ext_irq_i = '0;
      rd(4'h0, d); chk("R1 R6 ext pending", d, pendf(16 + n) | 32'h400800);
      ack();
      rd(4'h0, d); chk("R11 R5 ext active", d, 32'(16 + n) | 32'h800);
      cmpl(16 + n);
      rd(4'h0, d); chk("R12 ext complete", d, 32'h800);
    end

    // R10 R5 ordered pair sweep
    for (int a = 0; a < NE - 1; a++) begin
      for (int b = a + 1; b < NE; b++) begin
        ext_irq_i[b] = 1'b1; ext_irq_i[a] = 1'b1; cyc(); ext_irq_i = '0;
        rd(4'h0, d); chk("R10 lowest wins", d, pendf(16 + a) | 32'h400800);
        ack(); ack();
        rd(4'h0, d); chk("R5 nested active", d, 32'(16 + a));
        cmpl(16 + a); cmpl(16 + b);
      end
    end

    // R9 trigger range sweep
    for (int v = 0; v < 2 * NE; v++) begin
      wr(4'h8, 32'hFFFF_FE00 | 32'(v));
      rd(4'h0, d);
      chk("R9 trigger", d, (v < NE) ? (pendf(16 + v) | 32'h400800) : 32'h800);
      drain();
    end

    // R3 R4 set/clear pair sweep
    for (int prev = 0; prev < 2; prev++) begin
      for (int code = 0; code < 4; code++) begin
        wr(4'h0, prev[0] ? 32'h1000_0000 : 32'h0800_0000);
        wr(4'h0, {3'b000, code[1], code[0], 27'd0});
        pv = code[1] | (prev[0] & ~code[0]);
        rd(4'h0, d); chk("R3 pendsv pair", {31'd0, d[28]}, {31'd0, pv});
        wr(4'h0, prev[0] ? 32'h0400_0000 : 32'h0200_0000);
        wr(4'h0, {5'b00000, code[1], code[0], 25'd0});
        rd(4'h0, d); chk("R4 tick pair", {31'd0, d[26]}, {31'd0, pv});
        wr(4'h0, 32'h0A00_0000);
      end
    end

    // R4 tick pulse, R7 active bits
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    rd(4'h0, d); chk("R4 R6 tick pulse", d, pendf(15) | 32'h0400_0800);
    ack();
    rd(4'h4, d); chk("R7 tick active", d, 32'h800);
    cmpl(15);
    wr(4'h0, 32'h1000_0000); ack();
    rd(4'h4, d); chk("R7 pendsv active", d, 32'h400);
    cmpl(14);

    // R2 NMI beats external
    wr(4'h0, 32'h8000_0000);
    ext_irq_i[0] = 1'b1; cyc(); ext_irq_i = '0;
    rd(4'h0, d); chk("R2 nmi pending", d, pendf(2) | 32'h8040_0800);
    ack();
    rd(4'h0, d); chk("R2 nmi active", d, 32'h0040_0802 | pendf(16));
    cmpl(2); drain();

    // R8 fault enables
    sys_pend_i[4] = 1'b1; cyc(); sys_pend_i = '0;
    rd(4'h4, d); chk("R8 masked fault pending", d, 32'h2000);
    rd(4'h0, d); chk("R8 masked not selected", d, 32'h800);
    wr(4'h4, 32'h0001_0000);
    rd(4'h0, d); chk("R8 enabled selected", d, pendf(4) | 32'h800);
    ack();
    rd(4'h4, d); chk("R7 R8 mem active", d, 32'h0001_0001);
    cmpl(4);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R8 enable readback", d, 32'h0007_0000);
    sys_pend_i[6] = 1'b1; sys_pend_i[5] = 1'b1; sys_pend_i[11] = 1'b1; cyc(); sys_pend_i = '0;
    rd(4'h4, d); chk("R8 fault pending bits", d, 32'h0007_D000);
    ack(); ack(); ack();
    rd(4'h4, d); chk("R7 fault active bits", d, 32'h0007_008A);
    rd(4'h0, d); chk("R5 multi active", d, 32'h5);
    cmpl(5); cmpl(6); cmpl(11);
    sys_pend_i[12] = 1'b1; cyc(); sys_pend_i = '0; ack();
    rd(4'h4, d); chk("R7 debug active", d, 32'h0007_0100);
    cmpl(12);

    // R13 undefined offsets
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); chk("R13 undefined read", d, 32'h0);
    rd(4'h2, d); chk("R13 unaligned read", d, 32'h0);
    rd(4'h0, d); chk("R13 write ignored", d, 32'h800);

    // R11 ack with nothing pending
    ack();
    rd(4'h0, d); chk("R11 idle ack", d, 32'h800);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule